// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block sits at the address input of a synchronous burst static memory and produces the word address presented to the array on every cycle. A load captures an external address together with a chip-enable flag on the rising clock edge. Two strobes can start a load. One is driven by a processor and the other by a memory controller. After a load, the block walks through the remaining three words of a four-word burst. It moves one word for each cycle in which the advance input is high, so a full burst follows a 3-1-1-1 access pattern.

The burst order for the low address bits is set by a static order input. In linear order, the low bits count upward from the loaded value and wrap. In interleaved order, the low bits are the loaded low bits XORed with the beat count. The upper address bits stay fixed for the whole burst.

The chip-enable flag is registered with the address, so a deselect takes effect at the next access. This supports depth expansion across several memory banks without adding a cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets the word address to zero and the registered select to 0.
- R2: When the controller strobe is high on a rising edge, the word address equals the address input and the select equals the chip-enable input from the next cycle on.
- R3: When the registered select is 1, the processor strobe loads in the same way as R2. When both strobes are high on the same edge, exactly one load of the presented address takes place.
- R4: When the registered select is 0, a processor strobe with no controller strobe has no effect: the word address and the select keep their values.
- R5: With order input 1 (linear), each advance after a load gives low bits equal to (loaded low bits + beat) modulo 4, for beats 1, 2 and 3.
- R6: With order input 0 (interleaved), each advance gives low bits equal to (loaded low bits XOR beat), for beats 1, 2 and 3.
- R7: An advance never changes the address bits above the two low burst bits.
- R8: With no strobe and no advance, the word address and the select hold their values.
- R9: A fourth advance after a load wraps the beat count to 0, so the word address returns to the loaded address.
- R10: A load on the same edge as an advance takes precedence: the loaded address appears and the beat count restarts at 0.
- R11: A load with chip enable 0 sets the select to 0, and the next load with chip enable 1 sets it back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address captured on a load |
| ce_i | input | 1 | Chip enable captured on a load |
| strobe_proc_i | input | 1 | Processor address strobe; takes effect only while sel_o is 1 |
| strobe_ctrl_i | input | 1 | Controller address strobe |
| adv_i | input | 1 | Steps the burst by one word |
| order_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| word_addr_o | output | ADDR_W | Registered word address sent to the array |
| sel_o | output | 1 | Registered chip enable |

## Verification
The bench builds the block with ADDR_W = 8 and BURST_BITS = 2. At this size, every value of the upper byte field can be written in a compact vector table. It also gives a load at 0xFF, so the linear wrap of the low bits can be checked against an unchanged upper field. Both orders are walked through a full burst and its wrap. Further vectors cover the processor strobe with the select at 1 and at 0, both strobes together with an advance, and a deselecting load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear_i,
  input  logic                  step_i,
  output logic [BURST_BITS-1:0] beat_o,
  output logic [BURST_BITS-1:0] beat_next_o
);
  localparam logic [BURST_BITS-1:0] ONE  = BURST_BITS'(1);
  localparam logic [BURST_BITS-1:0] LAST = {BURST_BITS{1'b1}};

  always_comb begin
    if (clear_i)     beat_next_o = '0;
    else if (step_i) beat_next_o = beat_o + ONE;
    else             beat_next_o = beat_o;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_o <= '0;
    else     beat_o <= beat_next_o;
  end

  // R9: the count wraps after the last beat instead of saturating
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && beat_o == LAST) |=> (beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic [BURST_BITS-1:0] base_lo_i,
  input  logic [BURST_BITS-1:0] beat_i,
  input  burst_order_e          order_i,
  output logic [BURST_BITS-1:0] lo_o
);
  logic [BURST_BITS-1:0] lin_lo;
  logic [BURST_BITS-1:0] ilv_lo;

  assign lin_lo = base_lo_i + beat_i;

  for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
    assign ilv_lo[b] = base_lo_i[b] ^ beat_i[b];
  end

  assign lo_o = (order_i == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/strobe_arbiter.sv
module strobe_arbiter (
  input  logic strobe_proc_i,
  input  logic strobe_ctrl_i,
  input  logic sel_q_i,
  output logic load_o,
  output logic proc_win_o
);
  logic proc_ok;
  assign proc_ok    = strobe_proc_i && sel_q_i;
  assign proc_win_o = proc_ok;
  assign load_o     = proc_ok || strobe_ctrl_i;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_i,
  input  logic              strobe_proc_i,
  input  logic              strobe_ctrl_i,
  input  logic              adv_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              sel_o
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic                  load;
  logic                  proc_win;
  logic                  step;
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] beat_q;
  logic [BURST_BITS-1:0] beat_nx;
  logic [BURST_BITS-1:0] mapped_lo;
  logic [ADDR_W-1:0]     addr_nx;
  burst_order_e          order;

  assign order = burst_order_e'(order_i);
  assign step  = adv_i && !load;

  strobe_arbiter u_arb (
    .strobe_proc_i (strobe_proc_i),
    .strobe_ctrl_i (strobe_ctrl_i),
    .sel_q_i       (sel_o),
    .load_o        (load),
    .proc_win_o    (proc_win)
  );

  burst_beat_counter #(.BURST_BITS(BURST_BITS)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (load),
    .step_i      (step),
    .beat_o      (beat_q),
    .beat_next_o (beat_nx)
  );

  burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
    .base_lo_i (base_q[BURST_BITS-1:0]),
    .beat_i    (beat_nx),
    .order_i   (order),
    .lo_o      (mapped_lo)
  );

  always_comb begin
    if (load)      addr_nx = addr_i;
    else if (step) addr_nx = {base_q[ADDR_W-1:BURST_BITS], mapped_lo};
    else           addr_nx = word_addr_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q      <= '0;
      sel_o       <= 1'b0;
      word_addr_o <= '0;
    end else begin
      word_addr_o <= addr_nx;
      if (load) begin
        base_q <= addr_i;
        sel_o  <= ce_i;
      end
    end
  end

  // R2: controller strobe captures address
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    strobe_ctrl_i |=> (word_addr_o == $past(addr_i)));
  // R3: processor strobe with select high captures address, even alongside controller
  a_r3_proc_load: assert property (@(posedge clk) disable iff (rst)
    proc_win |=> (word_addr_o == $past(addr_i)));
  // R4: processor strobe ignored while deselected
  a_r4_proc_ignored: assert property (@(posedge clk) disable iff (rst)
    (strobe_proc_i && !sel_o && !strobe_ctrl_i && !adv_i) |=>
      ($stable(word_addr_o) && $stable(sel_o)));
  // R7: upper address bits fixed while advancing
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !strobe_ctrl_i && !(strobe_proc_i && sel_o)) |=>
      (word_addr_o[ADDR_W-1 -: HI_W] == $past(word_addr_o[ADDR_W-1 -: HI_W])));
  // R8: idle cycles hold state
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !strobe_ctrl_i && !strobe_proc_i) |=>
      ($stable(word_addr_o) && $stable(sel_o)));
  // R11: select follows captured chip enable
  a_r11_sel_capture: assert property (@(posedge clk) disable iff (rst)
    strobe_ctrl_i |=> (sel_o == $past(ce_i)));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          ce_i = 1'b0;
  logic          sp_i = 1'b0;
  logic          sc_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          ord_i = 1'b0;
  logic [AW-1:0] word_addr_o;
  logic          sel_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
    .clk (clk), .rst (rst), .addr_i (addr_i), .ce_i (ce_i),
    .strobe_proc_i (sp_i), .strobe_ctrl_i (sc_i), .adv_i (adv_i),
    .order_i (ord_i), .word_addr_o (word_addr_o), .sel_o (sel_o)
  );

  // Row: req[25:22] ce[21] sp[20] sc[19] adv[18] ord[17] addr[16:9] exp_addr[8:1] exp_sel[0]
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  1'b1,1'b0,1'b1,1'b0,1'b1, 8'h5D, 8'h5D, 1'b1}, // R2 controller load
    {4'd5,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h5E, 1'b1}, // R5 beat 1
    {4'd5,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h5F, 1'b1}, // R5 beat 2
    {4'd5,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h5C, 1'b1}, // R5 beat 3 wraps low bits
    {4'd9,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h5D, 1'b1}, // R9 fourth advance
    {4'd8,  1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h5D, 1'b1}, // R8 hold
    {4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'hA6, 8'hA6, 1'b1}, // R3 processor load
    {4'd6,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'hA7, 1'b1}, // R6 beat 1
    {4'd6,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'hA4, 1'b1}, // R6 beat 2
    {4'd6,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'hA5, 1'b1}, // R6 beat 3
    {4'd9,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'hA6, 1'b1}, // R9 interleaved wrap
    {4'd10, 1'b1,1'b1,1'b1,1'b1,1'b0, 8'h33, 8'h33, 1'b1}, // R10 both strobes + advance
    {4'd11, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'h40, 8'h40, 1'b0}, // R11 deselecting load
    {4'd4,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'h99, 8'h40, 1'b0}, // R4 processor strobe ignored
    {4'd7,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h41, 1'b0}, // R7 advance keeps upper bits
    {4'd11, 1'b1,1'b0,1'b1,1'b0,1'b1, 8'hFF, 8'hFF, 1'b1}, // R11 reselect
    {4'd7,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'hFC, 1'b1}  // R7 low wrap, upper kept
  };

  task automatic check(input int req, input logic [AW-1:0] exp_a, input logic exp_s);
    checks++;
    if (word_addr_o !== exp_a || sel_o !== exp_s) begin
      failures++;
      $display("FAIL R%0d: addr=%h sel=%b expected addr=%h sel=%b",
               req, word_addr_o, sel_o, exp_a, exp_s);
    end
  endtask

  task automatic idle();
    ce_i = 1'b0; sp_i = 1'b0; sc_i = 1'b0; adv_i = 1'b0; addr_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, '0, 1'b0); // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      ce_i   = VEC[i][21];
      sp_i   = VEC[i][20];
      sc_i   = VEC[i][19];
      adv_i  = VEC[i][18];
      ord_i  = VEC[i][17];
      addr_i = VEC[i][16:9];
      @(negedge clk);
      check(int'(VEC[i][25:22]), VEC[i][8:1], VEC[i][0]);
    end

    // R8: several idle cycles with noise on the address and chip enable
    idle(); addr_i = 8'h12; ce_i = 1'b0;
    repeat (3) @(negedge clk);
    check(8, 8'hFC, 1'b1);

    // R10: controller load while advancing restarts the burst at beat 0
    sc_i = 1'b1; ce_i = 1'b1; adv_i = 1'b1; ord_i = 1'b1; addr_i = 8'h82;
    @(negedge clk);
    check(10, 8'h82, 1'b1);
    sc_i = 1'b0; addr_i = '0;
    @(negedge clk);
    check(5, 8'h83, 1'b1); // R5 first beat after restart

    // R1: reset in mid-burst
    idle(); rst = 1'b1;
    @(negedge clk);
    check(1, '0, 1'b0);
    rst = 1'b0;

    // R4: processor strobe after reset is ignored (select is 0)
    sp_i = 1'b1; ce_i = 1'b1; addr_i = 8'h77;
    @(negedge clk);
    check(4, '0, 1'b0);
    idle();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule